// File: doc/BRIEF.md
# Pad Standby State Override

This block sits between a group of pad controllers and the pad drivers. It decides what each pad drives while the system is in IO standby. In normal operation it passes three signals through unchanged: the functional transmit value, the transmit enable and the pad's receive value. While standby is in force, each pad's own 4-bit standby code takes over. The code sets the transmit drive and the output enable. It also sets the value returned to the internal controller in place of the real receive signal.

A single standby request is shared by all pads and is registered once. Entry into standby and exit from it both take effect at the clock edge after the request changes. Each pad keeps a register with the last value it drove, so one standby code can keep the pad driving that value. Codes that the table does not define leave the pad in normal operation, as the explicit bypass code does.

Top module: `pad_stby_ovr`

## Requirements
- R1: During reset, and whenever standby is not in force, `pad_tx` = `fn_tx`, `pad_oe` = `fn_oe` and `ctl_rx` = `pad_rx` for every pad. Reset clears the standby state and the held values to 0.
- R2: Standby is in force from the first rising edge of `clk` at which `stby_req` is sampled 1. It ends at the first rising edge at which `stby_req` is sampled 0.
- R3: Code 0 in standby: `pad_oe`=1, `pad_tx` = the held last-driven value, and `ctl_rx` = `pad_rx`.
- R4: Codes 1, 2, 3 and 4 in standby: `pad_oe`=1. `pad_tx` is 0, 0, 1, 1 and `ctl_rx` is 0, 1, 0, 1, in that code order.
- R5: Codes 5 and 6 in standby: `pad_oe`=1, `pad_tx` is 0 or 1 respectively, and `ctl_rx` = `pad_rx`.
- R6: Codes 7 and 8 in standby: `pad_oe`=0 (high impedance) and `pad_tx`=0. `ctl_rx` is 0 or 1 respectively.
- R7: Code 9 in standby: `pad_oe`=0, `pad_tx`=0, and `ctl_rx` = `pad_rx`.
- R8: Code 15 and the undefined codes 10 to 14 leave the pad in normal operation even when standby is in force, with the same behaviour as R1.
- R9: At a clock edge, a pad's held value loads `fn_tx` when two conditions hold: `fn_oe` is 1, and the pad is in normal operation before that edge. Otherwise the held value keeps its contents. Pad i uses code bits `stby_code[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby request, shared by all pads |
| stby_code | input | 4*NUM_PADS | Per-pad standby code; pad i uses bits 4i+3:4i |
| fn_tx | input | NUM_PADS | Functional transmit value |
| fn_oe | input | NUM_PADS | Functional transmit enable |
| pad_rx | input | NUM_PADS | Receive value from the pad |
| pad_tx | output | NUM_PADS | Transmit value to the pad driver |
| pad_oe | output | NUM_PADS | Output enable to the pad driver |
| ctl_rx | output | NUM_PADS | Receive value delivered to the controller |

## Verification
The capture of the last driven value and the entry into standby can fall at the same clock edge. On that edge the pad is still in normal operation, so `fn_tx` is loaded. The edge also turns standby on, so code 0 drives that newly loaded value at once. The bench raises `stby_req` with code 0 and a fresh `fn_tx` pattern with the enable set. It then expects `pad_tx` to show that same pattern in the following cycle, and not the value captured before it. A second case tests the reverse: after exit from standby, a pattern presented with the enable low must not reach the held value.

// File: rtl/pad_stby_pkg.sv
package pad_stby_pkg;

   localparam int CODE_W = 4;

   // Sources for the transmit value
   typedef enum logic [1:0] {
      TXS_FUNC = 2'd0,
      TXS_HELD = 2'd1,
      TXS_ZERO = 2'd2,
      TXS_ONE  = 2'd3
   } tx_src_e;

   // Sources for the value returned to the controller
   typedef enum logic [1:0] {
      RXS_PAD  = 2'd0,
      RXS_ZERO = 2'd1,
      RXS_ONE  = 2'd2
   } rx_src_e;

   typedef struct packed {
      logic    override;
      tx_src_e tx_src;
      logic    oe_val;
      rx_src_e rx_src;
   } stby_ctl_t;

endpackage

// File: rtl/pss_req_stage.sv
module pss_req_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic act_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_o <= 1'b0;
      else        act_o <= req_i;
   end

endmodule

// File: rtl/pss_decode.sv
module pss_decode
   import pad_stby_pkg::*;
(
   input  logic              act_i,
   input  logic [CODE_W-1:0] code_i,
   output stby_ctl_t         ctl_o
);

   always_comb begin
      ctl_o = '{override: 1'b1, tx_src: TXS_ZERO, oe_val: 1'b1, rx_src: RXS_PAD};
      case (code_i)
         4'd0: ctl_o.tx_src = TXS_HELD;
         4'd1: ctl_o.rx_src = RXS_ZERO;
         4'd2: ctl_o.rx_src = RXS_ONE;
         4'd3: begin ctl_o.tx_src = TXS_ONE; ctl_o.rx_src = RXS_ZERO; end
         4'd4: begin ctl_o.tx_src = TXS_ONE; ctl_o.rx_src = RXS_ONE;  end
         4'd5: ctl_o.tx_src = TXS_ZERO;
         4'd6: ctl_o.tx_src = TXS_ONE;
         4'd7: begin ctl_o.oe_val = 1'b0; ctl_o.rx_src = RXS_ZERO; end
         4'd8: begin ctl_o.oe_val = 1'b0; ctl_o.rx_src = RXS_ONE;  end
         4'd9: ctl_o.oe_val = 1'b0;
         default: begin
            ctl_o.override = 1'b0;
            ctl_o.tx_src   = TXS_FUNC;
         end
      endcase
      if (!act_i) begin
         ctl_o.override = 1'b0;
         ctl_o.tx_src   = TXS_FUNC;
         ctl_o.oe_val   = 1'b1;
         ctl_o.rx_src   = RXS_PAD;
      end
   end

endmodule

// File: rtl/pss_hold.sv
module pss_hold #(
   parameter int   NUM_PADS  = 4,
   parameter logic HOLD_INIT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PADS-1:0] cap_en_i,
   input  logic [NUM_PADS-1:0] tx_i,
   output logic [NUM_PADS-1:0] held_o
);

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           held_o[p] <= HOLD_INIT;
         else if (cap_en_i[p]) held_o[p] <= tx_i[p];
      end
   end

endmodule

// File: rtl/pad_stby_ovr.sv
module pad_stby_ovr
   import pad_stby_pkg::*;
#(
   parameter int   NUM_PADS  = 4,
   parameter logic HOLD_INIT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stby_req,
   input  logic [CODE_W*NUM_PADS-1:0] stby_code,
   input  logic [NUM_PADS-1:0]        fn_tx,
   input  logic [NUM_PADS-1:0]        fn_oe,
   input  logic [NUM_PADS-1:0]        pad_rx,
   output logic [NUM_PADS-1:0]        pad_tx,
   output logic [NUM_PADS-1:0]        pad_oe,
   output logic [NUM_PADS-1:0]        ctl_rx
);

   localparam int CODE_BITS = CODE_W * NUM_PADS;

   initial begin
      if (NUM_PADS < 1) $error("pad_stby_ovr: NUM_PADS must be at least 1");
      if (CODE_W != 4)  $error("pad_stby_ovr: standby code must be 4 bits");
      if (CODE_BITS != $bits(stby_code)) $error("pad_stby_ovr: code bus width mismatch");
   end

   logic                act;
   logic [NUM_PADS-1:0] held;
   logic [NUM_PADS-1:0] cap_en;
   stby_ctl_t           ctl [NUM_PADS];

   pss_req_stage u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (stby_req),
      .act_o (act)
   );

   pss_hold #(
      .NUM_PADS  (NUM_PADS),
      .HOLD_INIT (HOLD_INIT)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en_i (cap_en),
      .tx_i     (fn_tx),
      .held_o   (held)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      pss_decode u_dec (
         .act_i  (act),
         .code_i (stby_code[CODE_W*p +: CODE_W]),
         .ctl_o  (ctl[p])
      );

      assign cap_en[p] = fn_oe[p] & ~ctl[p].override;

      always_comb begin
         unique case (ctl[p].tx_src)
            TXS_FUNC: pad_tx[p] = fn_tx[p];
            TXS_HELD: pad_tx[p] = held[p];
            TXS_ZERO: pad_tx[p] = 1'b0;
            TXS_ONE:  pad_tx[p] = 1'b1;
         endcase
         pad_oe[p] = ctl[p].override ? ctl[p].oe_val : fn_oe[p];
         case (ctl[p].rx_src)
            RXS_ZERO: ctl_rx[p] = 1'b0;
            RXS_ONE:  ctl_rx[p] = 1'b1;
            default:  ctl_rx[p] = pad_rx[p];
         endcase
      end
   end

endmodule

// File: rtl/pad_stby_ovr_chk.sv
module pad_stby_ovr_chk #(
   parameter int NUM_PADS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  stby_req,
   input logic [4*NUM_PADS-1:0] stby_code,
   input logic [NUM_PADS-1:0]   fn_tx,
   input logic [NUM_PADS-1:0]   fn_oe,
   input logic [NUM_PADS-1:0]   pad_rx,
   input logic [NUM_PADS-1:0]   pad_tx,
   input logic [NUM_PADS-1:0]   pad_oe,
   input logic [NUM_PADS-1:0]   ctl_rx
);

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
      // R1
      normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(stby_req)) |->
         (pad_tx[p] == fn_tx[p] && pad_oe[p] == fn_oe[p] && ctl_rx[p] == pad_rx[p]));

      // R3
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(rst_n, 2) && $past(stby_req) && $past(stby_req, 2)
          && stby_code[4*p +: 4] == 4'd0 && $past(stby_code[4*p +: 4]) == 4'd0)
         |-> ($stable(pad_tx[p]) && pad_oe[p]));

      // R4
      forced_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(stby_req) && stby_code[4*p +: 4] >= 4'd1
          && stby_code[4*p +: 4] <= 4'd4)
         |-> (pad_oe[p] && pad_tx[p] == (stby_code[4*p +: 4] >= 4'd3)
              && ctl_rx[p] == !stby_code[4*p]));

      // R6
      hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(stby_req) && (stby_code[4*p +: 4] == 4'd7
          || stby_code[4*p +: 4] == 4'd8))
         |-> (!pad_oe[p] && !pad_tx[p]));

      // R8
      bypass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(stby_req) && stby_code[4*p +: 4] >= 4'd10)
         |-> (pad_tx[p] == fn_tx[p] && pad_oe[p] == fn_oe[p] && ctl_rx[p] == pad_rx[p]));
   end

endmodule

bind pad_stby_ovr pad_stby_ovr_chk #(.NUM_PADS(NUM_PADS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stby_req  (stby_req),
   .stby_code (stby_code),
   .fn_tx     (fn_tx),
   .fn_oe     (fn_oe),
   .pad_rx    (pad_rx),
   .pad_tx    (pad_tx),
   .pad_oe    (pad_oe),
   .ctl_rx    (ctl_rx)
);

// File: tb/pad_stby_ovr_bench.sv
module pad_stby_ovr_bench;

   localparam int CLK_P = 10;
   localparam int N     = 4;

   typedef struct {
      logic [N-1:0] tx;
      logic [N-1:0] oe;
      logic [N-1:0] rx;
      string        tag;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           stby_req = 1'b0;
   logic [4*N-1:0] stby_code = '1;
   logic [N-1:0]   fn_tx = '0, fn_oe = '0, pad_rx = '0;
   logic [N-1:0]   pad_tx, pad_oe, ctl_rx;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   exp_t  sb_q[$];

   logic         m_act = 1'b0;
   logic [N-1:0] m_held = '0;

   always #(CLK_P/2) clk = ~clk;

   pad_stby_ovr #(.NUM_PADS(N)) u_pad_stby_ovr (
      .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .stby_code(stby_code),
      .fn_tx(fn_tx), .fn_oe(fn_oe), .pad_rx(pad_rx),
      .pad_tx(pad_tx), .pad_oe(pad_oe), .ctl_rx(ctl_rx)
   );

   function automatic bit forced(logic act, logic [3:0] c);
      return act && (c <= 4'd9);
   endfunction

   function automatic exp_t model(string tag);
      exp_t e;
      e.tag = tag;
      for (int i = 0; i < N; i++) begin
         logic [3:0] c = stby_code[4*i +: 4];
         e.tx[i] = fn_tx[i]; e.oe[i] = fn_oe[i]; e.rx[i] = pad_rx[i];
         if (forced(m_act, c)) begin
            case (c)
               4'd0: begin e.tx[i] = m_held[i]; e.oe[i] = 1'b1; end
               4'd1, 4'd2, 4'd3, 4'd4: begin
                  e.tx[i] = (c >= 4'd3); e.oe[i] = 1'b1; e.rx[i] = ~c[0];
               end
               4'd5, 4'd6: begin e.tx[i] = (c == 4'd6); e.oe[i] = 1'b1; end
               4'd7, 4'd8: begin e.tx[i] = 1'b0; e.oe[i] = 1'b0; e.rx[i] = (c == 4'd8); end
               default: begin e.tx[i] = 1'b0; e.oe[i] = 1'b0; end
            endcase
         end
      end
      return e;
   endfunction

   task automatic compare(exp_t e);
      checks++;
      if (pad_tx !== e.tx || pad_oe !== e.oe || ctl_rx !== e.rx) begin
         errors++;
         $display("FAIL %s: tx/oe/rx actual %b/%b/%b expected %b/%b/%b",
                  e.tag, pad_tx, pad_oe, ctl_rx, e.tx, e.oe, e.rx);
      end
   endtask

   // One clock step: drive at negedge, model the next rising edge, push result
   task automatic step(logic req, logic [4*N-1:0] code, logic [N-1:0] tx,
                       logic [N-1:0] oe, logic [N-1:0] rx, string tag);
      @(negedge clk);
      stby_req = req; stby_code = code; fn_tx = tx; fn_oe = oe; pad_rx = rx;
      for (int i = 0; i < N; i++)
         if (oe[i] && !forced(m_act, code[4*i +: 4])) m_held[i] = tx[i];
      m_act = req;
      sb_q.push_back(model(tag));
   endtask

   // Monitor: compares a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (sb_q.size() > 0) compare(sb_q.pop_front());
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1 reset: standby requested during reset has no effect
      stby_req = 1'b1; stby_code = '0; fn_tx = 4'b0110; fn_oe = 4'b1010; pad_rx = 4'b1100;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      compare('{tx: 4'b0110, oe: 4'b1010, rx: 4'b1100, tag: "R1 reset"});
      @(negedge clk);
      stby_req = 1'b0;
      rst_n = 1'b1;

      step(0, 16'hFFFF, 4'b1001, 4'b0110, 4'b0011, "R1 pass pattern a");
      step(0, 16'h0000, 4'b1010, 4'b1111, 4'b1110, "R1 pass pattern b, R9 capture");
      // Same edge: capture and standby entry (R2, R3)
      step(1, 16'h0000, 4'b0101, 4'b1111, 4'b0001, "R2 entry R3 fresh hold");
      step(1, 16'h0000, 4'b0000, 4'b1111, 4'b1000, "R3 hold kept, R9 no capture");
      step(1, 16'h4321, 4'b1111, 4'b0000, 4'b1111, "R4 forced 1..4");
      step(1, 16'h6565, 4'b1111, 4'b0000, 4'b1010, "R5 drive with rx");
      step(1, 16'hF987, 4'b1100, 4'b1010, 4'b0110, "R6 R7 R8 hiz/rx-only/bypass");
      step(1, 16'hEDCA, 4'b0011, 4'b0101, 4'b1001, "R8 undefined codes");
      step(0, 16'h0000, 4'b1111, 4'b0000, 4'b0101, "R2 exit, R9 no capture oe=0");
      step(1, 16'h0000, 4'b0000, 4'b0000, 4'b0000, "R9 held unchanged after exit");
      step(1, 16'h0F0F, 4'b1111, 4'b1111, 4'b0000, "R9 mixed capture");
      step(1, 16'h0000, 4'b0000, 4'b0000, 4'b0000, "R9 R3 per-pad capture");
      step(0, 16'h2222, 4'b0110, 4'b1100, 4'b0011, "R2 R1 request low");

      repeat (3) @(posedge clk);
      #(CLK_P/2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule